// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Complete

This block collects a fixed set of level-sensitive interrupt lines and routes them to a fixed set of target contexts. Each context has its own external interrupt output. Software configures the block through a small 32-bit register bus that has an address, a write strobe, write data, a read strobe and read data. Each source carries a programmable priority. Each context has an enable bitmap and a priority threshold.

A context's output is high while some source meets all of these conditions: it is pending, it is enabled for that context, it is not already in service, and its priority is strictly above the context's threshold. A handler reads the context's claim register and receives the identifier of the best such source. That read also marks the source as in service, so no other context can claim it. When the handler finishes, it writes the same identifier back to the register to complete the interrupt. Identifier 0 means "no interrupt", and line 0 is never used as a source.

Top module: `irq_platform_ctrl`

## Requirements
- R1: Reset clears all priorities, thresholds, enable words, pending bits and in-service bits, and drives every context output, the read data and the error flag low.
- R2: The pending bit of source i (i >= 1) equals the level of line i sampled at the previous clock edge. Line 0 never becomes pending. The pending region at PEND_BASE is a read-only array in which bit i of word w is source 32*w+i. Writes to it change nothing and raise the error flag.
- R3: The priority of source id (1 <= id < NUM_SRC) is at byte address PRIO_BASE + 4*(id-1). When PRIO_MAX+1 is a power of two, a priority or threshold write keeps only the low log2(PRIO_MAX+1) bits of the data.
- R4: When PRIO_MAX+1 is not a power of two, a priority or threshold write whose data exceeds PRIO_MAX is discarded, and the register keeps its old value.
- R5: Enable word w of context c is at EN_BASE + c*EN_STRIDE + 4*w, and bit i of that word enables source 32*w+i. A word index of (NUM_SRC+31)/32 or more is not stored and raises the error flag.
- R6: Within context c's block at CTX_BASE + c*CTX_STRIDE, offset 0 holds the threshold and offset 4 is claim/complete. Any other offset changes nothing, reads as 0 and raises the error flag.
- R7: The winner of a context is chosen among sources that are pending, enabled, not in service, and have a priority strictly above the threshold. It is the source with the highest priority, and the lowest identifier wins a tie. The context output is high exactly one clock after the state that gives it a winner.
- R8: Reading claim returns the context's winner, clears that source's pending bit and marks it in service, which removes it from every context. With no winner, the read returns 0 and changes no state.
- R9: Writing a value v to claim/complete ends the in-service mark of source v only when v < NUM_SRC. Larger values are ignored.
- R10: Read data appears one clock after the read strobe and is 0 in any cycle that follows no read. An access with a misaligned address, or one that falls outside every region, changes nothing, reads 0 and raises the error flag one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; takes precedence over a same-cycle write |
| bus_rdata | output | 32 | Read data, one clock after the read strobe |
| bus_err | output | 1 | Invalid-access flag, one clock after the access |
| irq_src | input | NUM_SRC | Level interrupt lines; bit 0 is unused |
| ctx_irq | output | NUM_CTX | External interrupt request per context |

## Verification
If an in-service mark is wrong, it shows at the very next claim read. A source that was marked wrongly never comes back from claim, and a source whose mark was lost is returned twice, even before the context output changes. A wrong pending bit or enable bit shows in the context output two clocks after the line changes, and it also shows in the source returned by the next claim. A priority compare that is off by one shows only when priorities tie or when a priority equals the threshold, so the bench sweeps every line pattern against a table that contains both of those cases. Legal-value handling is checked by reading every write back on two instances, one in each legalization mode.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // Region hit by a bus address after decoding.
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_PRIO  = 3'd1,
    RG_PEND  = 3'd2,
    RG_EN    = 3'd3,
    RG_THR   = 3'd4,
    RG_CLAIM = 3'd5
  } region_e;

  // True when v+1 is a power of two, selecting mask-style legalization.
  function automatic bit all_ones(input int unsigned v);
    return ((v + 1) & v) == 0;
  endfunction

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/irq_src_state.sv
module irq_src_state #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] claim_set_i,
  input  logic [NUM_SRC-1:0] cmpl_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] busy_o
);

  // Line 0 is reserved as the "no interrupt" identifier.
  localparam logic [NUM_SRC-1:0] LIVE = ~NUM_SRC'(1);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      busy_q <= '0;
    end else begin
      // A claim in the same cycle wins over the sampled line level.
      pend_q <= src_i & ~claim_set_i & LIVE;
      busy_q <= (busy_q & ~cmpl_i) | claim_set_i;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

  for (genvar k = 1; k < NUM_SRC; k++) begin : g_chk
    a_r8_claim_marks: assert property (@(posedge clk) disable iff (rst)
      claim_set_i[k] |=> busy_q[k] && !pend_q[k]);
    a_r9_complete_frees: assert property (@(posedge clk) disable iff (rst)
      cmpl_i[k] && !claim_set_i[k] |=> !busy_q[k]);
    a_r2_pend_tracks_line: assert property (@(posedge clk) disable iff (rst)
      !claim_set_i[k] |=> pend_q[k] == $past(src_i[k]));
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned NUM_CTX  = 2,
  parameter int unsigned PRIO_MAX = 7,
  localparam int unsigned BFW  = (NUM_SRC + 31) / 32,
  localparam int unsigned ENN  = NUM_CTX * BFW,
  localparam int unsigned ENW  = clog2_min1(ENN),
  localparam int unsigned PW   = clog2_min1(PRIO_MAX + 1),
  localparam int unsigned IDW  = clog2_min1(NUM_SRC),
  localparam int unsigned CTXW = clog2_min1(NUM_CTX)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          prio_we_i,
  input  logic [IDW-1:0]                prio_id_i,
  input  logic                          thr_we_i,
  input  logic [CTXW-1:0]               thr_ctx_i,
  input  logic                          en_we_i,
  input  logic [ENW-1:0]                en_idx_i,
  input  logic [31:0]                   wdata_i,
  output logic [NUM_SRC-1:0][PW-1:0]    prio_o,
  output logic [NUM_CTX-1:0][PW-1:0]    thr_o,
  output logic [ENN-1:0][31:0]          en_o
);

  localparam bit MASK_MODE = all_ones(PRIO_MAX);

  logic          lvl_ok;
  logic [PW-1:0] lvl_val;

  if (MASK_MODE) begin : g_mask
    // Every bit pattern of the kept width is a legal level.
    assign lvl_ok  = 1'b1;
    assign lvl_val = wdata_i[PW-1:0];
  end else begin : g_range
    // Out-of-range levels are dropped entirely.
    assign lvl_ok  = wdata_i <= 32'(PRIO_MAX);
    assign lvl_val = wdata_i[PW-1:0];
  end

  logic [NUM_SRC-1:0][PW-1:0] prio_q;
  logic [NUM_CTX-1:0][PW-1:0] thr_q;
  logic [ENN-1:0][31:0]       en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      thr_q  <= '0;
      en_q   <= '0;
    end else begin
      if (prio_we_i && lvl_ok) prio_q[prio_id_i] <= lvl_val;
      if (thr_we_i && lvl_ok)  thr_q[thr_ctx_i]  <= lvl_val;
      if (en_we_i)             en_q[en_idx_i]    <= wdata_i;
    end
  end

  assign prio_o = prio_q;
  assign thr_o  = thr_q;
  assign en_o   = en_q;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_thr_chk
    a_r4_thr_in_range: assert property (@(posedge clk) disable iff (rst)
      thr_we_i && thr_ctx_i == CTXW'(c) && wdata_i > 32'(PRIO_MAX) && !MASK_MODE
      |=> $stable(thr_q[c]));
  end

endmodule

// File: rtl/irq_ctx_select.sv
module irq_ctx_select #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PW      = 3,
  parameter int unsigned IDW     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         cand_i,
  input  logic [NUM_SRC-1:0][PW-1:0] prio_i,
  input  logic [PW-1:0]              thr_i,
  output logic [IDW-1:0]             win_id_o,
  output logic                       win_vld_o
);

  logic [PW-1:0]  best;
  logic [IDW-1:0] id;
  logic           vld;

  // Ascending scan with a strict compare: ties go to the lowest identifier.
  always_comb begin
    best = thr_i;
    id   = '0;
    vld  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && prio_i[i] > best) begin
        best = prio_i[i];
        id   = IDW'(i);
        vld  = 1'b1;
      end
    end
  end

  assign win_id_o  = id;
  assign win_vld_o = vld;

  a_r7_winner_qualifies: assert property (@(posedge clk) disable iff (rst)
    win_vld_o |-> cand_i[win_id_o] && prio_i[win_id_o] > thr_i);
  a_r7_empty_no_winner: assert property (@(posedge clk) disable iff (rst)
    cand_i == '0 |-> !win_vld_o);

endmodule

// File: rtl/irq_platform_ctrl.sv
module irq_platform_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned PRIO_MAX   = 7,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_re,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic [NUM_CTX-1:0] ctx_irq
);

  localparam int unsigned BFW  = (NUM_SRC + 31) / 32;
  localparam int unsigned ENN  = NUM_CTX * BFW;
  localparam int unsigned ENW  = clog2_min1(ENN);
  localparam int unsigned WW   = clog2_min1(BFW);
  localparam int unsigned PW   = clog2_min1(PRIO_MAX + 1);
  localparam int unsigned IDW  = clog2_min1(NUM_SRC);
  localparam int unsigned CTXW = clog2_min1(NUM_CTX);
  localparam int unsigned PADW = BFW * 32;

  localparam logic [31:0] PR_B   = 32'(PRIO_BASE);
  localparam logic [31:0] PD_B   = 32'(PEND_BASE);
  localparam logic [31:0] EN_B   = 32'(EN_BASE);
  localparam logic [31:0] CX_B   = 32'(CTX_BASE);
  localparam logic [31:0] EN_S   = 32'(EN_STRIDE);
  localparam logic [31:0] CX_S   = 32'(CTX_STRIDE);
  localparam logic [31:0] PR_SPN = 32'((NUM_SRC - 1) * 4);
  localparam logic [31:0] PD_SPN = 32'(BFW * 4);
  localparam logic [31:0] EN_SPN = 32'(NUM_CTX * EN_STRIDE);
  localparam logic [31:0] CX_SPN = 32'(NUM_CTX * CTX_STRIDE);
  localparam logic [31:0] N_SRC  = 32'(NUM_SRC);

  // ---------------- address decode ----------------
  logic [31:0]     a32, o_pr, o_pd, o_en, o_cx, en_in, cx_in;
  region_e         rg;
  logic [IDW-1:0]  dec_id;
  logic [CTXW-1:0] dec_ctx;
  logic [WW-1:0]   dec_w;

  always_comb begin
    a32     = 32'(bus_addr);
    o_pr    = a32 - PR_B;
    o_pd    = a32 - PD_B;
    o_en    = a32 - EN_B;
    o_cx    = a32 - CX_B;
    en_in   = (o_en & (EN_S - 32'd1)) >> 2;
    cx_in   = o_cx & (CX_S - 32'd1);
    rg      = RG_NONE;
    dec_id  = '0;
    dec_ctx = '0;
    dec_w   = '0;
    if (a32 >= PR_B && o_pr < PR_SPN) begin
      rg     = RG_PRIO;
      dec_id = IDW'((o_pr >> 2) + 32'd1);
    end else if (a32 >= PD_B && o_pd < PD_SPN) begin
      rg    = RG_PEND;
      dec_w = WW'(o_pd >> 2);
    end else if (a32 >= EN_B && o_en < EN_SPN) begin
      dec_ctx = CTXW'(o_en / EN_S);
      dec_w   = WW'(en_in);
      if (en_in < 32'(BFW)) rg = RG_EN;
    end else if (a32 >= CX_B && o_cx < CX_SPN) begin
      dec_ctx = CTXW'(o_cx / CX_S);
      if (cx_in == 32'd0)      rg = RG_THR;
      else if (cx_in == 32'd4) rg = RG_CLAIM;
    end
    if (bus_addr[1:0] != 2'b00) rg = RG_NONE;
  end

  logic do_rd, do_wr;
  assign do_rd = bus_re;
  assign do_wr = bus_we && !bus_re;

  // ---------------- configuration storage ----------------
  logic [NUM_SRC-1:0][PW-1:0] prio;
  logic [NUM_CTX-1:0][PW-1:0] thr;
  logic [ENN-1:0][31:0]       en_w;
  logic [ENW-1:0]             en_idx;

  assign en_idx = ENW'(int'(dec_ctx) * BFW + int'(dec_w));

  irq_cfg_regs #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_MAX(PRIO_MAX)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .prio_we_i(do_wr && rg == RG_PRIO),
    .prio_id_i(dec_id),
    .thr_we_i (do_wr && rg == RG_THR),
    .thr_ctx_i(dec_ctx),
    .en_we_i  (do_wr && rg == RG_EN),
    .en_idx_i (en_idx),
    .wdata_i  (bus_wdata),
    .prio_o   (prio),
    .thr_o    (thr),
    .en_o     (en_w)
  );

  // ---------------- source state ----------------
  logic [NUM_SRC-1:0] pend, busy, claim_set, cmpl;

  irq_src_state #(.NUM_SRC(NUM_SRC)) u_src (
    .clk        (clk),
    .rst        (rst),
    .src_i      (irq_src),
    .claim_set_i(claim_set),
    .cmpl_i     (cmpl),
    .pend_o     (pend),
    .busy_o     (busy)
  );

  // ---------------- per-context selection ----------------
  logic [NUM_CTX-1:0][NUM_SRC-1:0] cand;
  logic [NUM_CTX-1:0][IDW-1:0]     win_id;
  logic [NUM_CTX-1:0]              win_vld;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      assign cand[c][i] = pend[i] && !busy[i] && en_w[c*BFW + i/32][i%32];
    end
    irq_ctx_select #(
      .NUM_SRC(NUM_SRC),
      .PW     (PW),
      .IDW    (IDW)
    ) u_sel (
      .clk      (clk),
      .rst      (rst),
      .cand_i   (cand[c]),
      .prio_i   (prio),
      .thr_i    (thr[c]),
      .win_id_o (win_id[c]),
      .win_vld_o(win_vld[c])
    );
  end

  // ---------------- claim / complete side effects ----------------
  logic claim_hit;
  assign claim_hit = do_rd && rg == RG_CLAIM && win_vld[dec_ctx];
  assign claim_set = claim_hit ? (NUM_SRC'(1) << win_id[dec_ctx]) : '0;
  assign cmpl      = (do_wr && rg == RG_CLAIM && bus_wdata < N_SRC)
                     ? (NUM_SRC'(1) << bus_wdata[IDW-1:0]) : '0;

  // ---------------- read mux and output registers ----------------
  logic [PADW-1:0] pend_pad;
  logic [31:0]     rd_nx;
  logic            err_nx;

  assign pend_pad = PADW'(pend);

  always_comb begin
    rd_nx = '0;
    if (do_rd) begin
      case (rg)
        RG_PRIO:  rd_nx = 32'(prio[dec_id]);
        RG_PEND:  rd_nx = pend_pad[dec_w*32 +: 32];
        RG_EN:    rd_nx = en_w[en_idx];
        RG_THR:   rd_nx = 32'(thr[dec_ctx]);
        RG_CLAIM: rd_nx = win_vld[dec_ctx] ? 32'(win_id[dec_ctx]) : 32'd0;
        default:  rd_nx = '0;
      endcase
    end
    err_nx = (do_rd || do_wr) && (rg == RG_NONE || (do_wr && rg == RG_PEND));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      ctx_irq   <= '0;
    end else begin
      bus_rdata <= rd_nx;
      bus_err   <= err_nx;
      ctx_irq   <= win_vld;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> ctx_irq == '0 && bus_rdata == '0 && !bus_err);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == '0);
  a_r7_irq_one_late: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ctx_irq == $past(win_vld));
  a_r8_empty_claim: assert property (@(posedge clk) disable iff (rst)
    do_rd && rg == RG_CLAIM && !win_vld[dec_ctx] |=> bus_rdata == '0 && $stable(busy));
  a_r2_pend_write_flag: assert property (@(posedge clk) disable iff (rst)
    do_wr && rg == RG_PEND |=> bus_err);

endmodule

// File: tb/irq_platform_ctrl_tb.sv
module irq_platform_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int NCTX = 2;
  localparam logic [15:0] PR = 16'h0000, PD = 16'h1000, EN = 16'h2000;
  localparam logic [15:0] ENS = 16'h0080, CX = 16'h4000, CXS = 16'h1000;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [NSRC-1:0] src = '0;
  logic [31:0] rdata_a, rdata_b;
  logic err_a, err_b;
  logic [NCTX-1:0] irq_a, irq_b;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_platform_ctrl #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_MAX(7)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_re(re), .bus_rdata(rdata_a), .bus_err(err_a), .irq_src(src), .ctx_irq(irq_a));

  irq_platform_ctrl #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_MAX(5)) u_dut_odd (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_re(re), .bus_rdata(rdata_b), .bus_err(err_b), .irq_src(src), .ctx_irq(irq_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    e = err_a;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] da, output logic [31:0] db, output logic e);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    da = rdata_a; db = rdata_b; e = err_a;
  endtask

  int p[8] = '{0, 2, 5, 5, 1, 7, 2, 3};

  function automatic int win(int pat, int cl, int en, int thr);
    int best = thr;
    int w = 0;
    for (int i = 1; i < NSRC; i++)
      if (pat[i] && en[i] && !cl[i] && p[i] > best) begin
        best = p[i];
        w = i;
      end
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] da, db;
    logic e;
    int mb;
    int w0, w0b, w1, cl;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(irq_a == 0 && irq_b == 0, "R1 outputs", 32'(irq_a), 0);
    for (int id = 1; id < NSRC; id++) begin
      rd(PR + 16'(4*(id-1)), da, db, e);
      chk(da == 0 && db == 0, "R1 priority", da, 0);
    end
    rd(PD, da, db, e);                 chk(da == 0, "R1 pending", da, 0);
    rd(EN, da, db, e);                 chk(da == 0, "R1 enable ctx0", da, 0);
    rd(EN + ENS, da, db, e);           chk(da == 0, "R1 enable ctx1", da, 0);
    rd(CX, da, db, e);                 chk(da == 0, "R1 threshold", da, 0);

    // R3/R4: priority legalization sweep on both instances
    for (int id = 1; id < NSRC; id++) begin
      mb = 0;
      for (int v = 0; v < 16; v++) begin
        wr(PR + 16'(4*(id-1)), 32'(v), e);
        if (v <= 5) mb = v;
        rd(PR + 16'(4*(id-1)), da, db, e);
        chk(da == 32'(v & 7), "R3 priority mask", da, 32'(v & 7));
        chk(db == 32'(mb), "R4 priority discard", db, 32'(mb));
      end
    end
    // R3: distinct values prove the per-source address map
    for (int id = 1; id < NSRC; id++) wr(PR + 16'(4*(id-1)), 32'(p[id]), e);
    for (int id = 1; id < NSRC; id++) begin
      rd(PR + 16'(4*(id-1)), da, db, e);
      chk(da == 32'(p[id]), "R3 priority map", da, 32'(p[id]));
    end

    // R3/R4 on thresholds via the R6 context block offset 0
    for (int c = 0; c < NCTX; c++) begin
      mb = 0;
      for (int v = 0; v < 10; v++) begin
        wr(CX + 16'(c)*CXS, 32'(v), e);
        if (v <= 5) mb = v;
        rd(CX + 16'(c)*CXS, da, db, e);
        chk(da == 32'(v & 7), "R3 R6 threshold mask", da, 32'(v & 7));
        chk(db == 32'(mb), "R4 threshold discard", db, 32'(mb));
      end
    end

    // R2: pending follows every line pattern; bit 0 never pending
    for (int pat = 0; pat < 256; pat++) begin
      @(negedge clk);
      src = 8'(pat);
      rd(PD, da, db, e);
      chk(da == 32'(pat & 8'hFE), "R2 pending level", da, 32'(pat & 8'hFE));
    end
    src = '0;
    wr(PD, 32'hFF, e);
    chk(e == 1'b1, "R2 pending write flagged", 32'(e), 1);
    rd(PD, da, db, e);
    chk(da == 0, "R2 pending write ignored", da, 0);

    // R5: enable words, and an out-of-range word index
    wr(EN, 32'h0000_00FE, e);
    wr(EN + ENS, 32'h0000_000F, e);
    wr(EN + 16'h4, 32'hFFFF_FFFF, e);
    chk(e == 1'b1, "R5 bad word flagged", 32'(e), 1);
    rd(EN, da, db, e);        chk(da == 32'hFE, "R5 enable ctx0", da, 32'hFE);
    rd(EN + ENS, da, db, e);  chk(da == 32'h0F, "R5 enable ctx1", da, 32'h0F);
    wr(CX, 32'd1, e);
    wr(CX + CXS, 32'd0, e);

    // R7/R8/R9: every pattern, two claims on ctx0, one on ctx1, then complete
    for (int pat = 0; pat < 256; pat++) begin
      @(negedge clk);
      src = 8'(pat);
      repeat (2) @(negedge clk);
      w0 = win(pat, 0, 'hFE, 1);
      w1 = win(pat, 0, 'h0F, 0);
      chk(irq_a[0] == (w0 != 0), "R7 ctx0 output", 32'(irq_a[0]), 32'(w0 != 0));
      chk(irq_a[1] == (w1 != 0), "R7 ctx1 output", 32'(irq_a[1]), 32'(w1 != 0));
      cl = 0;
      rd(CX + 16'h4, da, db, e);
      chk(da == 32'(w0), "R8 ctx0 claim", da, 32'(w0));
      if (w0 != 0) cl |= (1 << w0);
      w0b = win(pat, cl, 'hFE, 1);
      rd(CX + 16'h4, da, db, e);
      chk(da == 32'(w0b), "R8 ctx0 second claim", da, 32'(w0b));
      if (w0b != 0) cl |= (1 << w0b);
      w1 = win(pat, cl, 'h0F, 0);
      rd(CX + CXS + 16'h4, da, db, e);
      chk(da == 32'(w1), "R8 ctx1 claim excludes in-service", da, 32'(w1));
      if (w1 != 0) cl |= (1 << w1);
      for (int i = 1; i < NSRC; i++) if (cl[i]) wr(CX + 16'h4, 32'(i), e);
      @(negedge clk);
      chk(irq_a[0] == (w0 != 0), "R9 complete restores", 32'(irq_a[0]), 32'(w0 != 0));
    end

    // R9: out-of-range completion values are ignored
    @(negedge clk);
    src = 8'h20;
    repeat (2) @(negedge clk);
    rd(CX + 16'h4, da, db, e);  chk(da == 5, "R8 claim id5", da, 5);
    wr(CX + 16'h4, 32'd8, e);
    rd(CX + 16'h4, da, db, e);  chk(da == 0, "R9 value 8 ignored", da, 0);
    wr(CX + 16'h4, 32'hFFFF_FFFF, e);
    @(negedge clk);
    chk(irq_a[0] == 1'b0, "R9 large value ignored", 32'(irq_a[0]), 0);
    wr(CX + 16'h4, 32'd5, e);
    @(negedge clk);
    chk(irq_a[0] == 1'b1, "R9 valid complete", 32'(irq_a[0]), 1);

    // R7: threshold compare is strict
    wr(CX, 32'd7, e);
    @(negedge clk);
    chk(irq_a[0] == 1'b0, "R7 equal to threshold", 32'(irq_a[0]), 0);
    wr(CX, 32'd6, e);
    @(negedge clk);
    chk(irq_a[0] == 1'b1, "R7 above threshold", 32'(irq_a[0]), 1);

    // R6: other context offsets
    wr(CX + 16'h8, 32'd3, e);
    chk(e == 1'b1, "R6 bad offset write flagged", 32'(e), 1);
    rd(CX, da, db, e);          chk(da == 6, "R6 threshold unchanged", da, 6);
    rd(CX + 16'h8, da, db, e);
    chk(e == 1'b1 && da == 0, "R6 bad offset read", da, 0);

    // R10: misaligned, unmapped, and a clean access
    wr(PR + 16'h1, 32'd0, e);
    chk(e == 1'b1, "R10 misaligned flagged", 32'(e), 1);
    rd(PR, da, db, e);
    chk(da == 2 && e == 1'b0, "R10 misaligned ignored", da, 2);
    rd(16'h8000, da, db, e);
    chk(da == 0 && e == 1'b1, "R10 unmapped read", da, 0);
    @(negedge clk);
    chk(rdata_a == 0, "R10 idle read data", rdata_a, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule